// File: doc/BRIEF.md
# Fractional M/N Clock-Enable Generator

This block derives a slower reference rate from its input clock by issuing a stream of single-cycle enable pulses. Their long-run rate is the input rate multiplied by the ratio M/N. It does not gate the clock. Logic downstream runs on the input clock and acts only in cycles where `clk_en` is high. A phase accumulator produces the fractional ratio. Each cycle it adds M and takes N away whenever the sum reaches N, so the pulses are spread as evenly as the ratio allows.

All control goes through one 32-bit control word. N sits in bits [30:16], M in bits [15:1], the output enable in bit 0, and an update request in bit 31. A write stores the new M and N in a staging copy only. The ratio that drives the accumulator changes only when the written word carries the update bit. That bit clears itself one cycle later, when the staged ratio is copied into the running divider and the accumulator restarts from zero. The enable bit acts at once. A ratio where M is zero, N is zero or M exceeds N is invalid, and it keeps the output low.

Top module: `mn_frac_div`

## Requirements
- R1: During reset and in the first cycle after reset, `clk_en` is 0 and `cfg_rdata` reads 0. This covers an active ratio of 0/0 and a disabled output.
- R2: `cfg_rdata` returns the last written word, with N at bits [30:16], M at bits [15:1] and the enable at bit 0. Bit 31 reads 0 once any pending update has been taken.
- R3: A write with bit 31 set shows bit 31 = 1 in `cfg_rdata` for exactly one cycle. The bit then reads 0 without any further write.
- R4: With a valid active ratio where M equals N and the enable set, `clk_en` is high in every cycle, which passes the clock straight through.
- R5: With a valid active ratio and the enable set, every window of N consecutive cycles holds exactly M cycles with `clk_en` high.
- R6: After an update, the staged ratio loads at the next clock edge and the accumulator is cleared. The first pulse then appears in the k-th cycle after the load edge, where k = ceil(N/M).
- R7: While enable bit 0 of the stored word is 0, `clk_en` stays low. Clearing or setting the enable takes effect without an update request.
- R8: An active ratio with M = 0, N = 0 or M > N produces no `clk_en` pulses.
- R9: A write without bit 31 leaves the running ratio unchanged. The pulse count per window still follows the previously loaded M and N.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock that is divided |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 32 | Control word: [31] update, [30:16] N, [15:1] M, [0] enable |
| cfg_rdata | output | 32 | Stored control word, with bit 31 showing a pending update |
| clk_en | output | 1 | Single-cycle enable pulse, average rate M/N of `clk` |

## Verification
The properties assume that a write carrying the update bit is not immediately followed by another such write. Under that assumption the pending bit is free to clear itself, so the stimulus always leaves at least one idle cycle after each write. The pass-through and invalid-ratio properties also assume that the accumulator only moves while the divider runs. For this reason, every pulse count in the bench starts only after the load cycle and a few settling cycles, and each window is a whole multiple of N.

// File: rtl/mn_div_pkg.sv
package mn_div_pkg;

    localparam int TERM_W = 15;
    localparam int WORD_W = 2 * TERM_W + 2;
    localparam int SUM_W  = TERM_W + 1;

    // Bit order of the packed struct matches the control-word layout.
    typedef struct packed {
        logic              upd;
        logic [TERM_W-1:0] n;
        logic [TERM_W-1:0] m;
        logic              en;
    } ctl_word_t;

    typedef struct packed {
        logic [TERM_W-1:0] m;
        logic [TERM_W-1:0] n;
    } ratio_t;

    function automatic logic ratio_ok(input ratio_t r);
        return (r.m != '0) && (r.n != '0) && (r.m <= r.n);
    endfunction

endpackage

// File: rtl/mn_cfg_reg.sv
module mn_cfg_reg
    import mn_div_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [WORD_W-1:0] wdata,
    output ctl_word_t         stored,
    output ratio_t            active,
    output logic              load
);

    ctl_word_t stored_q;
    ratio_t    active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stored_q <= '0;
            active_q <= '0;
        end else begin
            if (stored_q.upd) begin
                active_q.m <= stored_q.m;
                active_q.n <= stored_q.n;
            end
            if (wr) begin
                stored_q <= ctl_word_t'(wdata);
            end else if (stored_q.upd) begin
                stored_q.upd <= 1'b0;
            end
        end
    end

    assign stored = stored_q;
    assign active = active_q;
    assign load   = stored_q.upd;

endmodule

// File: rtl/mn_ratio_accum.sv
module mn_ratio_accum
    import mn_div_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              step,
    input  ratio_t            ratio,
    output logic              fire,
    output logic [TERM_W-1:0] acc
);

    logic [TERM_W-1:0] acc_q;
    logic [SUM_W-1:0]  sum;
    logic [SUM_W-1:0]  wrapped;

    always_comb begin
        sum     = {1'b0, acc_q} + {1'b0, ratio.m};
        fire    = step && (sum >= {1'b0, ratio.n});
        wrapped = sum - {1'b0, ratio.n};
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            acc_q <= '0;
        end else if (step) begin
            acc_q <= fire ? wrapped[TERM_W-1:0] : sum[TERM_W-1:0];
        end
    end

    assign acc = acc_q;

endmodule

// File: rtl/mn_out_gate.sv
module mn_out_gate
    import mn_div_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   en,
    input  logic   pending,
    input  ratio_t ratio,
    input  logic   fire,
    output logic   run,
    output logic   pulse
);

    logic pulse_q;

    assign run = en && !pending && ratio_ok(ratio);

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= run && fire;
        end
    end

    assign pulse = pulse_q;

endmodule

// File: rtl/mn_frac_div.sv
module mn_frac_div
    import mn_div_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [WORD_W-1:0] cfg_wdata,
    output logic [WORD_W-1:0] cfg_rdata,
    output logic              clk_en
);

    ctl_word_t         stored;
    ratio_t            active;
    logic              load;
    logic              run;
    logic              fire;
    logic [TERM_W-1:0] acc_val;
    logic [TERM_W-1:0] act_m;
    logic [TERM_W-1:0] act_n;

    mn_cfg_reg u_cfg (
        .clk    (clk),
        .rst    (rst),
        .wr     (cfg_wr),
        .wdata  (cfg_wdata),
        .stored (stored),
        .active (active),
        .load   (load)
    );

    mn_ratio_accum u_acc (
        .clk   (clk),
        .rst   (rst),
        .clear (load),
        .step  (run),
        .ratio (active),
        .fire  (fire),
        .acc   (acc_val)
    );

    mn_out_gate u_gate (
        .clk     (clk),
        .rst     (rst),
        .en      (stored.en),
        .pending (load),
        .ratio   (active),
        .fire    (fire),
        .run     (run),
        .pulse   (clk_en)
    );

    assign cfg_rdata = stored;
    assign act_m     = active.m;
    assign act_n     = active.n;

endmodule

// File: rtl/mn_frac_div_chk.sv
module mn_frac_div_chk
    import mn_div_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cfg_wr,
    input logic [WORD_W-1:0] cfg_wdata,
    input logic [WORD_W-1:0] cfg_rdata,
    input logic              clk_en,
    input logic [TERM_W-1:0] act_m,
    input logic [TERM_W-1:0] act_n,
    input logic [TERM_W-1:0] acc
);

    logic bad_ratio;
    assign bad_ratio = (act_m == '0) || (act_n == '0) || (act_m > act_n);

    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!clk_en && cfg_rdata == '0));

    a_r3_update_clears: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata[WORD_W-1] && !(cfg_wr && cfg_wdata[WORD_W-1])) |=> !cfg_rdata[WORD_W-1]);

    a_r4_passthrough: assert property (@(posedge clk) disable iff (rst)
        (!bad_ratio && act_m == act_n && cfg_rdata[0] && !cfg_rdata[WORD_W-1]) |=> clk_en);

    a_r5_acc_bounded: assert property (@(posedge clk) disable iff (rst)
        !bad_ratio |-> (acc < act_n));

    a_r7_gate_off: assert property (@(posedge clk) disable iff (rst)
        !cfg_rdata[0] |=> !clk_en);

    a_r8_invalid_quiet: assert property (@(posedge clk) disable iff (rst)
        bad_ratio |=> !clk_en);

endmodule

bind mn_frac_div mn_frac_div_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_wr    (cfg_wr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .clk_en    (clk_en),
    .act_m     (act_m),
    .act_n     (act_n),
    .acc       (acc_val)
);

// File: tb/mn_frac_div_bench.sv
`timescale 1ns/1ps
module mn_frac_div_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        clk_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mn_frac_div u_mn_frac_div (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .clk_en    (clk_en)
    );

    // m, n, enable, window, expected pulse count in window
    localparam int NV = 10;
    localparam int VM[NV] = '{1, 3, 5, 2, 0, 6, 9,  7, 1, 13};
    localparam int VN[NV] = '{1, 8, 7, 4, 5, 0, 4,  7, 16, 100};
    localparam int VE[NV] = '{1, 1, 1, 1, 1, 1, 1,  0, 1, 1};
    localparam int VW[NV] = '{6, 16, 14, 8, 10, 8, 8, 14, 32, 200};
    localparam int VX[NV] = '{6, 6, 10, 4, 0, 0, 0, 0, 2, 26};

    task automatic check_eq(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] word(input bit upd, input int n, input int m, input bit en);
        return {upd, n[14:0], m[14:0], en};
    endfunction

    // Drive one write; returns at the negedge after the write edge.
    task automatic write_word(input logic [31:0] w);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_wdata = w;
        @(negedge clk);
        cfg_wr = 1'b0;
        cfg_wdata = '0;
    endtask

    task automatic count_pulses(input int cycles, output int cnt);
        cnt = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (clk_en) cnt++;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int cnt;
        // R1: reset state
        repeat (3) @(negedge clk);
        check_eq("R1 rdata in reset", cfg_rdata, 0);
        check_eq("R1 clk_en in reset", clk_en, 0);
        rst = 1'b0;
        @(negedge clk);
        check_eq("R1 rdata after reset", cfg_rdata, 0);
        count_pulses(8, cnt);
        check_eq("R1 no pulses after reset", cnt, 0);

        // Table: R2 readback, R3 self-clear, R4/R5/R7/R8 pulse counts
        for (int v = 0; v < NV; v++) begin
            write_word(word(1'b1, VN[v], VM[v], VE[v][0]));
            check_eq("R3 update pending", cfg_rdata[31], 1);
            @(negedge clk);
            check_eq("R3 update cleared", cfg_rdata[31], 0);
            check_eq("R2 readback", cfg_rdata, word(1'b0, VN[v], VM[v], VE[v][0]));
            repeat (3) @(negedge clk);
            count_pulses(VW[v], cnt);
            if (VM[v] == VN[v] && VE[v] != 0)
                check_eq("R4 pass-through count", cnt, VX[v]);
            else if (VE[v] == 0)
                check_eq("R7 disabled count", cnt, VX[v]);
            else if (VM[v] == 0 || VN[v] == 0 || VM[v] > VN[v])
                check_eq("R8 invalid count", cnt, VX[v]);
            else
                check_eq("R5 window count", cnt, VX[v]);
        end

        // R6: first pulse position after load, k = ceil(N/M)
        begin
            int tm[2] = '{3, 2};
            int tn[2] = '{10, 5};
            for (int t = 0; t < 2; t++) begin
                int pos;
                write_word(word(1'b1, tn[t], tm[t], 1'b0));
                repeat (2) @(negedge clk);
                write_word(word(1'b1, tn[t], tm[t], 1'b1));
                @(posedge clk);
                pos = 0;
                for (int i = 1; i <= 40; i++) begin
                    @(posedge clk);
                    @(negedge clk);
                    if (clk_en && pos == 0) pos = i;
                    if (pos != 0) break;
                end
                check_eq("R6 first pulse cycle", pos, (tn[t] + tm[t] - 1) / tm[t]);
            end
        end

        // R9: write without update keeps old ratio
        write_word(word(1'b1, 2, 1, 1'b1));
        repeat (4) @(negedge clk);
        write_word(word(1'b0, 1, 1, 1'b1));
        repeat (2) @(negedge clk);
        count_pulses(8, cnt);
        check_eq("R9 old ratio kept", cnt, 4);
        write_word(word(1'b1, 1, 1, 1'b1));
        repeat (3) @(negedge clk);
        count_pulses(8, cnt);
        check_eq("R9 new ratio after update", cnt, 8);

        // R7: enable acts without update
        write_word(word(1'b0, 1, 1, 1'b0));
        @(negedge clk);
        count_pulses(8, cnt);
        check_eq("R7 enable cleared", cnt, 0);
        write_word(word(1'b0, 1, 1, 1'b1));
        @(negedge clk);
        count_pulses(8, cnt);
        check_eq("R7 enable set again", cnt, 8);

        // R1: reset in the middle of running
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check_eq("R1 clk_en on mid reset", clk_en, 0);
        check_eq("R1 rdata on mid reset", cfg_rdata, 0);
        rst = 1'b0;
        count_pulses(8, cnt);
        check_eq("R1 quiet after mid reset", cnt, 0);

        finish_run();
    end

endmodule